// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits on the receive side of an Ethernet controller, after deserialization. It watches the received byte stream and, from the leading six bytes of each frame (the destination address), decides whether the frame is wanted.

Individual (unicast) addresses are compared with a programmable station address. An optional promiscuous setting accepts every unicast frame. Group (multicast) addresses are not compared against a list. Instead, a CRC-32 runs over the address bytes, and the upper six bits of that CRC pick one bit out of a 64-bit hash filter. The all-ones broadcast address has its own enable.

The result appears one cycle after the sixth address byte. It is a one-cycle valid strobe, an accept flag and a group/individual match-type flag. The accept flag and the match-type flag hold their values until the next start of frame. All filter settings are loaded through a small byte-wide write port.

Top module: `dest_addr_filter`

## Requirements
- R1: The write port loads one byte per cycle in which `cfgWrEn` is high. Addresses 0 to 5 hold the station address, with address 0 holding the byte received first. Addresses 6 to 13 hold the 64-bit hash filter: filter bit n is bit n%8 of address 6+n/8. Address 14 is the mode byte: bit 0 enables broadcast, and bit 1 enables promiscuous unicast. Reset clears every one of these settings to zero.
- R2: A byte with `rxValid` and `rxSof` both high is address byte 0. The next five bytes that carry `rxValid` are address bytes 1 to 5. Cycles with `rxValid` low are skipped. Bytes after the sixth do not change any output.
- R3: `decValid` is high for exactly one cycle: the cycle after the clock edge that takes address byte 5. It stays low at all other times.
- R4: `decAccept` and `decIsMcast` are zero from reset. Both are cleared by the edge that takes a start-of-frame byte. From the moment `decValid` rises, both keep their value until the next start-of-frame.
- R5: A frame is individual when bit 0 of address byte 0 is 0. Such a frame is accepted exactly when all six bytes equal the station address. The frame then reports `decIsMcast` = 0.
- R6: With promiscuous unicast enabled, every individual frame is accepted, whatever its address.
- R7: A group frame (bit 0 of byte 0 set) that is not all-ones is handled through the hash filter. A CRC-32 runs over the six bytes, least significant bit of each byte first. It uses polynomial 0x04C11DB7, starts from all ones, and has no final inversion. The hash index is CRC bits 31..26, with bit 31 as the index MSB. The frame is accepted exactly when the filter bit at that index is set, and it reports `decIsMcast` = 1.
- R8: An all-ones (broadcast) destination is accepted exactly when the broadcast enable is set, whatever the hash filter holds. It reports `decIsMcast` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration byte address |
| cfgData | input | 8 | Configuration write data |
| rxSof | input | 1 | Marks the first byte of a frame |
| rxValid | input | 1 | Received byte is valid |
| rxByte | input | 8 | Received byte |
| decValid | output | 1 | One-cycle strobe: decision available |
| decAccept | output | 1 | Frame accepted |
| decIsMcast | output | 1 | 1 = group address, 0 = individual address |

## Verification
The hardest case to reach from the ports is a group frame that hits the hash filter. That requires knowing which of the 64 filter bits the CRC of a given address selects. The stimulus therefore computes the index with an independent reflected CRC formulation. It then sets exactly that filter bit and checks acceptance. It also sets a neighbouring bit alone and checks rejection, so a wrong bit order in the index is exposed. Broadcast is run with its own hash bit set and the enable cleared, which separates the broadcast path from the hash path.

// File: rtl/dest_filter_pkg.sv
`timescale 1ns/1ps
package dest_filter_pkg;

  localparam int ADDR_BYTES = 6;
  localparam int IDX_W      = 3;
  localparam int CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;

  // Strobes from control to datapath
  typedef struct packed {
    logic             start;  // current byte is address byte 0
    logic             load;   // current byte belongs to the address field
    logic             last;   // current byte is the final address byte
    logic [IDX_W-1:0] idx;    // position of current byte in the field
  } filtStrobe_t;

  // One byte through the CRC register, data bits least significant first
  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] c,
                                               input logic [7:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int b = 0; b < 8; b++) begin
      fb = r[CRC_W-1] ^ d[b];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return r;
  endfunction

endpackage

// File: rtl/dest_filter_ctrl.sv
`timescale 1ns/1ps
module dest_filter_ctrl
  import dest_filter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxSof,
  input  logic        rxValid,
  output filtStrobe_t stb,
  output logic        decValid
);

  localparam logic [IDX_W-1:0] IDLE_CNT = IDX_W'(ADDR_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

  logic [IDX_W-1:0] byteCnt;  // next expected index; IDLE_CNT when field done

  always_comb begin
    stb.start = rxValid & rxSof;
    stb.load  = rxValid & (rxSof | (byteCnt < IDLE_CNT));
    stb.idx   = rxSof ? '0 : byteCnt;
    stb.last  = stb.load & (stb.idx == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt  <= IDLE_CNT;
      decValid <= 1'b0;
    end else begin
      if (stb.load) byteCnt <= stb.idx + 1'b1;
      decValid <= stb.last;
    end
  end

  // R2: counter never leaves its legal range
  always_comb begin
    if (rstN) assert_cnt_range_R2: assert (byteCnt <= IDLE_CNT);
  end

  assert_valid_follows_last_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.last |=> decValid);

  assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> !decValid);

endmodule

// File: rtl/dest_filter_dpath.sv
`timescale 1ns/1ps
module dest_filter_dpath
  import dest_filter_pkg::*;
#(
  parameter int CFG_AW = 4,
  parameter int HASH_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]        cfgData,
  input  logic [7:0]        rxByte,
  input  filtStrobe_t       stb,
  output logic              decAccept,
  output logic              decIsMcast
);

  localparam int HASH_N     = 1 << HASH_W;
  localparam int HASH_BYTES = HASH_N / 8;
  localparam int HASH_BASE  = ADDR_BYTES;
  localparam int MODE_ADDR  = HASH_BASE + HASH_BYTES;

  logic [ADDR_BYTES-1:0][7:0] staAddr;
  logic [HASH_N-1:0]          hashMap;
  logic                       bcastEn, promEn;

  // Configuration registers
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : gSta
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) staAddr[g] <= '0;
      else if (cfgWrEn && cfgAddr == CFG_AW'(g)) staAddr[g] <= cfgData;
    end
  end

  for (genvar h = 0; h < HASH_BYTES; h++) begin : gHash
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) hashMap[h*8 +: 8] <= '0;
      else if (cfgWrEn && cfgAddr == CFG_AW'(HASH_BASE + h)) hashMap[h*8 +: 8] <= cfgData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bcastEn <= 1'b0;
      promEn  <= 1'b0;
    end else if (cfgWrEn && cfgAddr == CFG_AW'(MODE_ADDR)) begin
      bcastEn <= cfgData[0];
      promEn  <= cfgData[1];
    end
  end

  // Running state over the address field
  logic [CRC_W-1:0] crcReg, crcCur, crcNxt;
  logic             eqReg, eqNxt;
  logic             grpReg, grpNxt;
  logic             onesReg, onesNxt;
  logic [HASH_W-1:0] hashIdx;
  logic             hashHit, acceptNow;

  always_comb begin
    crcCur    = stb.start ? '1 : crcReg;
    crcNxt    = crcByte(crcCur, rxByte);
    eqNxt     = (stb.start ? 1'b1 : eqReg) & (rxByte == staAddr[stb.idx]);
    grpNxt    = stb.start ? rxByte[0] : grpReg;
    onesNxt   = (stb.start ? 1'b1 : onesReg) & (rxByte == 8'hFF);
    hashIdx   = crcNxt[CRC_W-1 -: HASH_W];
    hashHit   = hashMap[hashIdx];
    acceptNow = grpNxt ? (onesNxt ? bcastEn : hashHit) : (eqNxt | promEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg  <= '1;
      eqReg   <= 1'b0;
      grpReg  <= 1'b0;
      onesReg <= 1'b0;
    end else if (stb.load) begin
      crcReg  <= crcNxt;
      eqReg   <= eqNxt;
      grpReg  <= grpNxt;
      onesReg <= onesNxt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decAccept  <= 1'b0;
      decIsMcast <= 1'b0;
    end else if (stb.last) begin
      decAccept  <= acceptNow;
      decIsMcast <= grpNxt;
    end else if (stb.start) begin
      decAccept  <= 1'b0;
      decIsMcast <= 1'b0;
    end
  end

  assert_sof_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.start && !stb.last) |=> (!decAccept && !decIsMcast));

  assert_decision_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.start && !stb.last) |=> ($stable(decAccept) && $stable(decIsMcast)));

  assert_start_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.start, stb.last}));

endmodule

// File: rtl/dest_addr_filter.sv
`timescale 1ns/1ps
module dest_addr_filter
  import dest_filter_pkg::*;
#(
  parameter int CFG_AW = 4,
  parameter int HASH_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]        cfgData,
  input  logic              rxSof,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  output logic              decValid,
  output logic              decAccept,
  output logic              decIsMcast
);

  filtStrobe_t stb;

  dest_filter_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxSof    (rxSof),
    .rxValid  (rxValid),
    .stb      (stb),
    .decValid (decValid)
  );

  dest_filter_dpath #(.CFG_AW(CFG_AW), .HASH_W(HASH_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgAddr    (cfgAddr),
    .cfgData    (cfgData),
    .rxByte     (rxByte),
    .stb        (stb),
    .decAccept  (decAccept),
    .decIsMcast (decIsMcast)
  );

endmodule

// File: tb/test_dest_addr_filter.sv
`timescale 1ns/1ps
module test_dest_addr_filter;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgWrEn;
  logic [3:0] cfgAddr;
  logic [7:0] cfgData;
  logic       rxSof, rxValid;
  logic [7:0] rxByte;
  logic       decValid, decAccept, decIsMcast;

  always #2.5 clk = ~clk;

  dest_addr_filter i_dest_addr_filter (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .rxSof(rxSof), .rxValid(rxValid), .rxByte(rxByte),
    .decValid(decValid), .decAccept(decAccept), .decIsMcast(decIsMcast)
  );

  typedef struct {
    bit    acc;
    bit    mc;
    string tag;
  } exp_t;

  exp_t q[$];
  int   nCmp = 0;
  int   nBad = 0;
  bit   done = 0;

  // Reference model of the filter settings
  bit [5:0][7:0] mSta;
  bit [63:0]     mHash;
  bit            mBc, mProm;

  task automatic chk(input string tag, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reflected CRC-32; index = non-reflected bits 31..26
  function automatic bit [5:0] hashOf(input bit [5:0][7:0] a);
    bit [31:0] r = 32'hFFFF_FFFF;
    bit fb;
    for (int i = 0; i < 6; i++)
      for (int b = 0; b < 8; b++) begin
        fb = r[0] ^ a[i][b];
        r  = r >> 1;
        if (fb) r ^= 32'hEDB8_8320;
      end
    return {r[0], r[1], r[2], r[3], r[4], r[5]};
  endfunction

  function automatic exp_t predict(input bit [5:0][7:0] a, input string tag);
    exp_t e;
    e.tag = tag;
    e.mc  = a[0][0];
    if (!a[0][0])           e.acc = (a == mSta) || mProm;
    else if (a == '1)       e.acc = mBc;
    else                    e.acc = mHash[hashOf(a)];
    return e;
  endfunction

  task automatic cfgWrite(input int addr, input bit [7:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 4'(addr); cfgData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (addr < 6) mSta[addr] = data;
    else if (addr < 14) mHash[(addr-6)*8 +: 8] = data;
    else if (addr == 14) begin mBc = data[0]; mProm = data[1]; end
  endtask

  task automatic setHashBit(input int n, input bit v);
    bit [7:0] cur;
    cur = mHash[(n/8)*8 +: 8];
    cur[n%8] = v;
    cfgWrite(6 + n/8, cur);
  endtask

  // Drives one frame: six address bytes, gap idle cycles between them, then trailing bytes
  task automatic sendFrame(input bit [5:0][7:0] a, input int gap, input string tag);
    exp_t e;
    e = predict(a, tag);
    q.push_back(e);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 1) chk({tag, " R4 cleared after start-of-frame"}, decAccept | decIsMcast, 0);
      rxValid = 1'b1; rxSof = (i == 0); rxByte = a[i];
      if (i < 5) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          rxValid = 1'b0; rxSof = 1'b0; rxByte = 8'($urandom);
        end
      end
    end
    @(negedge clk);
    rxValid = 1'b0; rxSof = 1'b0;
    chk({tag, " R3 valid after sixth byte"}, decValid, 1);
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      if (t == 0) chk({tag, " R3 valid lasts one cycle"}, decValid, 0);
      rxValid = 1'b1; rxByte = 8'($urandom);
    end
    @(negedge clk);
    rxValid = 1'b0;
    chk({tag, " R2 R4 held after trailing bytes"}, decAccept, e.acc);
    chk({tag, " R4 type held"}, decIsMcast, e.mc);
  endtask

  // Scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rstN && decValid) begin
        if (q.size() == 0) begin
          chk("R3 unexpected decision strobe", 1, 0);
        end else begin
          e = q.pop_front();
          chk({e.tag, " accept"}, decAccept, e.acc);
          chk({e.tag, " match type"}, decIsMcast, e.mc);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    bit [5:0][7:0] sta, mcA, mcB, bc;
    int ia, ib;
    rstN = 1'b0; cfgWrEn = 0; cfgAddr = 0; cfgData = 0;
    rxSof = 0; rxValid = 0; rxByte = 0;
    mSta = '0; mHash = '0; mBc = 0; mProm = 0;
    repeat (3) @(negedge clk);
    chk("R4 reset decValid", decValid, 0);
    chk("R4 reset decAccept", decAccept, 0);
    chk("R4 reset decIsMcast", decIsMcast, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: station address resets to zero, so an all-zero unicast matches
    sendFrame('0, 0, "R1 reset station address");
    sendFrame({8'h00,8'h00,8'h00,8'h00,8'h00,8'h02}, 0, "R1 reset promiscuous off");

    // R5: program station address (byte 0 first on the wire)
    sta = {8'h55,8'h44,8'h33,8'h22,8'h11,8'h02};
    for (int i = 0; i < 6; i++) cfgWrite(i, sta[i]);
    sendFrame(sta, 0, "R5 exact match");
    sendFrame(sta, 2, "R2 match with idle gaps");
    sendFrame({8'h54,sta[4:0]}, 0, "R5 last byte differs");
    sendFrame({sta[5:1],8'h06}, 1, "R5 first byte differs");

    // R6: promiscuous unicast
    cfgWrite(14, 8'h02);
    sendFrame({8'hAA,8'hBB,8'hCC,8'hDD,8'hEE,8'h10}, 0, "R6 promiscuous foreign unicast");
    cfgWrite(14, 8'h00);
    sendFrame({8'hAA,8'hBB,8'hCC,8'hDD,8'hEE,8'h10}, 0, "R6 promiscuous off");

    // R7: multicast through the hash filter
    mcA = {8'h01,8'h00,8'h00,8'h5E,8'h00,8'h01};
    mcB = {8'h33,8'h22,8'h11,8'h00,8'h80,8'h07};
    ia = hashOf(mcA);
    ib = hashOf(mcB);
    sendFrame(mcA, 0, "R7 empty hash filter");
    setHashBit(ia ^ 1, 1'b1);
    sendFrame(mcA, 0, "R7 neighbour bit only");
    setHashBit(ia, 1'b1);
    sendFrame(mcA, 3, "R7 hash hit");
    if (ib != ia) sendFrame(mcB, 0, "R7 other group not selected");
    setHashBit(ib, 1'b1);
    sendFrame(mcB, 0, "R7 second group hit");
    cfgWrite(14, 8'h02);
    setHashBit(ia, 1'b0);
    setHashBit(ia ^ 1, 1'b0);
    sendFrame(mcA, 0, "R6 R7 promiscuous leaves groups to hash");
    cfgWrite(14, 8'h00);

    // R8: broadcast
    bc = '1;
    setHashBit(hashOf(bc), 1'b1);
    sendFrame(bc, 0, "R8 broadcast disabled with hash bit");
    cfgWrite(14, 8'h01);
    setHashBit(hashOf(bc), 1'b0);
    sendFrame(bc, 0, "R8 broadcast enabled");
    sendFrame(sta, 0, "R4 accepted frame after broadcast");
    sendFrame({8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFE}, 0, "R8 near-broadcast unicast");

    repeat (4) @(negedge clk);
    chk("R3 scoreboard drained", q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule